// File: doc/BRIEF.md
# Serial Command Stream Processor

This block sits behind a host byte channel and interprets that channel as a stream of commands with their arguments. One stream carries four kinds of work, each decoded inline as it arrives: variable-length serial transfers for a separate shift engine, immediate writes to two 8-bit general-purpose pin ports, reads of those ports, and changes to the serial clock divisor.

A command byte with its most significant bit clear is a serial-data command. Two length bytes follow it. When the command asks for outbound data, a payload follows the length. The block hands the shift engine one command beat and then passes the payload bytes straight through. Command bytes with the top bit set act locally. A pin write takes the output levels first and then the direction mask, and the new levels and directions reach the pins together. A pin read returns one byte on the output stream. A divisor write loads a 16-bit value in one step. A command byte that cannot be decoded is echoed back behind a marker byte, and decoding carries on with the next byte.

Commands take effect strictly in arrival order. A new command byte is held off while the shift engine is still busy with an earlier transfer. During a transfer, the engine drives the low-port pins it owns.

Top module: `sercmd_dispatch`

## Requirements
- R1: After reset all pins of both ports are inputs (direction 0) with output level 0, the divisor is 0, and neither the output stream nor the engine command port is valid.
- R2: Command 0x80 followed by a level byte and then a mask byte sets the low port. A mask bit of 1 makes that pin an output. Levels and directions both change in the cycle after the mask byte is accepted, and neither changes earlier.
- R3: Command 0x82 sets the high port in the same way, with levels first and then the mask.
- R4: Command 0x81 returns the low-port input pins, and command 0x83 returns the high-port input pins. Each returns one byte, valid for one cycle, in the cycle after the command byte is accepted.
- R5: Command 0x86 takes the divisor low byte and then the high byte. Both halves update together after the high byte, giving a serial clock of 12 MHz / (2 × (divisor + 1)).
- R6: A command byte with bit 7 clear is followed by a 16-bit length, low byte first. The block then presents one engine command beat carrying command bits 6:0 and the length, and holds it until the engine accepts it.
- R7: If bit 4 of a serial command is 1, the next length+1 stream bytes go to the engine data port in order. If bit 4 is 0, no bytes go there, and the byte after the length is decoded as a command.
- R8: A command byte with bit 7 set other than 0x80 to 0x83 and 0x86 produces 0xFA and then that byte on the output stream in consecutive cycles, and decoding resumes at the next stream byte.
- R9: A command byte is not accepted while the engine reports busy, nor in the cycle after an engine command is accepted.
- R10: While the engine reports busy, the low-port output levels of the pins selected by parameter ENG_PINS (default 0x07) follow the engine's pin values. All other pins follow the written levels. Once the engine is idle, all pins return to the written levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Host stream byte present |
| in_data | input | 8 | Host stream byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| out_valid | output | 1 | Result byte valid for one cycle |
| out_data | output | 8 | Result byte |
| eng_cmd_valid | output | 1 | Engine command beat present |
| eng_cmd_ready | input | 1 | Engine takes the command beat |
| eng_cmd_op | output | 7 | Serial command bits 6:0 |
| eng_cmd_len | output | 16 | Transfer length minus one |
| eng_dat_valid | output | 1 | Payload byte present for the engine |
| eng_dat | output | 8 | Payload byte |
| eng_dat_ready | input | 1 | Engine takes the payload byte |
| eng_busy | input | 1 | Engine has a transfer in progress |
| eng_pin_val | input | 8 | Levels the engine drives on its owned low-port pins |
| gpio_lo_in | input | 8 | Low-port pin inputs |
| gpio_lo_out | output | 8 | Low-port output levels |
| gpio_lo_oe | output | 8 | Low-port output enables |
| gpio_hi_in | input | 8 | High-port pin inputs |
| gpio_hi_out | output | 8 | High-port output levels |
| gpio_hi_oe | output | 8 | High-port output enables |
| divisor | output | 16 | Serial clock divisor |

## Verification
The bench sends a pin write whose level byte already has clock bits set while the mask turns them into outputs. It samples between the level byte and the mask byte, so a design that applied the levels early, or the directions a cycle late, would show a glitch-prone intermediate state. It loads the divisor one byte at a time, which catches a half-updated divisor. It issues a read-only serial command followed directly by a read command, which exposes a parser that wrongly swallows payload bytes. It also sends an undecodable byte, which catches a parser that loses its place. It queues a pin write behind a long transfer and checks both the stall and the engine override on the owned pins, which catches a design that reorders commands or lets the engine disturb pins it does not own.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam logic [7:0] OP_WR_LO = 8'h80;
  localparam logic [7:0] OP_RD_LO = 8'h81;
  localparam logic [7:0] OP_WR_HI = 8'h82;
  localparam logic [7:0] OP_RD_HI = 8'h83;
  localparam logic [7:0] OP_DIV   = 8'h86;
  localparam logic [7:0] ERR_TAG  = 8'hFA;
  localparam int         DOUT_BIT = 4;

  typedef enum logic [2:0] {
    S_CMD, S_ARG1, S_ARG2, S_ISSUE, S_DATA, S_ERR
  } parse_state_t;
endpackage

// File: rtl/sercmd_parser.sv
module sercmd_parser
  import sercmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          eng_busy,
  output logic          eng_cmd_valid,
  input  logic          eng_cmd_ready,
  output logic [DW-2:0] eng_cmd_op,
  output logic [LW-1:0] eng_cmd_len,
  output logic          eng_dat_valid,
  output logic [DW-1:0] eng_dat,
  input  logic          eng_dat_ready,
  input  logic [DW-1:0] lo_in,
  input  logic [DW-1:0] hi_in,
  output logic          lo_wr,
  output logic          hi_wr,
  output logic [DW-1:0] wr_val,
  output logic [DW-1:0] wr_oe,
  output logic          div_wr,
  output logic [LW-1:0] div_val
);
  parse_state_t  state_q, state_d;
  logic [DW-1:0] cmd_q, cmd_d, arg_q, arg_d, od_q, od_d;
  logic [LW-1:0] len_q, len_d, cnt_q, cnt_d;
  logic          ov_q, ov_d, guard_q, guard_d;
  logic          hold_cmd, fire;

  assign hold_cmd    = eng_busy | guard_q;
  assign fire        = in_valid & in_ready;
  assign eng_cmd_op  = cmd_q[DW-2:0];
  assign eng_cmd_len = len_q;
  assign eng_dat     = in_data;
  assign wr_val      = arg_q;
  assign wr_oe       = in_data;
  assign div_val     = {in_data, arg_q};
  assign out_valid   = ov_q;
  assign out_data    = od_q;

  always_comb begin
    state_d = state_q; cmd_d = cmd_q; arg_d = arg_q; len_d = len_q;
    cnt_d = cnt_q; ov_d = 1'b0; od_d = od_q; guard_d = 1'b0;
    in_ready = 1'b0; eng_cmd_valid = 1'b0; eng_dat_valid = 1'b0;
    lo_wr = 1'b0; hi_wr = 1'b0; div_wr = 1'b0;
    case (state_q)
      S_CMD: begin
        in_ready = ~hold_cmd;
        if (fire) begin
          cmd_d = in_data;
          if (!in_data[DW-1]) state_d = S_ARG1;
          else begin
            case (in_data)
              OP_WR_LO, OP_WR_HI, OP_DIV: state_d = S_ARG1;
              OP_RD_LO: begin ov_d = 1'b1; od_d = lo_in; end
              OP_RD_HI: begin ov_d = 1'b1; od_d = hi_in; end
              default: begin ov_d = 1'b1; od_d = ERR_TAG; state_d = S_ERR; end
            endcase
          end
        end
      end
      S_ARG1: begin
        in_ready = 1'b1;
        if (fire) begin arg_d = in_data; state_d = S_ARG2; end
      end
      S_ARG2: begin
        in_ready = 1'b1;
        if (fire) begin
          state_d = S_CMD;
          if (!cmd_q[DW-1]) begin
            len_d   = {in_data, arg_q};
            state_d = S_ISSUE;
          end else begin
            lo_wr  = (cmd_q == OP_WR_LO);
            hi_wr  = (cmd_q == OP_WR_HI);
            div_wr = (cmd_q == OP_DIV);
          end
        end
      end
      S_ISSUE: begin
        eng_cmd_valid = 1'b1;
        if (eng_cmd_ready) begin
          guard_d = 1'b1;
          cnt_d   = '0;
          state_d = cmd_q[DOUT_BIT] ? S_DATA : S_CMD;
        end
      end
      S_DATA: begin
        in_ready      = eng_dat_ready;
        eng_dat_valid = in_valid;
        if (fire) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == len_q) state_d = S_CMD;
        end
      end
      S_ERR: begin
        ov_d = 1'b1; od_d = cmd_q; state_d = S_CMD;
      end
      default: state_d = S_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_CMD; cmd_q <= '0; arg_q <= '0; len_q <= '0;
      cnt_q <= '0; ov_q <= 1'b0; od_q <= '0; guard_q <= 1'b0;
    end else begin
      state_q <= state_d; cmd_q <= cmd_d; arg_q <= arg_d; len_q <= len_d;
      cnt_q <= cnt_d; ov_q <= ov_d; od_q <= od_d; guard_q <= guard_d;
    end
  end
endmodule

// File: rtl/sercmd_gpio_port.sv
module sercmd_gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] wr_oe,
  input  logic         ovr_en,
  input  logic [W-1:0] ovr_mask,
  input  logic [W-1:0] ovr_val,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic [W-1:0] val_q, val_d, oe_q, oe_d;

  always_comb begin
    val_d = val_q;
    oe_d  = oe_q;
    if (wr_en) begin
      val_d = wr_val;
      oe_d  = wr_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      oe_q  <= '0;
    end else begin
      val_q <= val_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_out = ovr_en ? ((val_q & ~ovr_mask) | (ovr_val & ovr_mask)) : val_q;
  assign pin_oe  = oe_q;
endmodule

// File: rtl/sercmd_dispatch.sv
module sercmd_dispatch #(
  parameter int         DW       = 8,
  parameter int         LW       = 16,
  parameter logic [7:0] ENG_PINS = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          eng_cmd_valid,
  input  logic          eng_cmd_ready,
  output logic [DW-2:0] eng_cmd_op,
  output logic [LW-1:0] eng_cmd_len,
  output logic          eng_dat_valid,
  output logic [DW-1:0] eng_dat,
  input  logic          eng_dat_ready,
  input  logic          eng_busy,
  input  logic [DW-1:0] eng_pin_val,
  input  logic [DW-1:0] gpio_lo_in,
  output logic [DW-1:0] gpio_lo_out,
  output logic [DW-1:0] gpio_lo_oe,
  input  logic [DW-1:0] gpio_hi_in,
  output logic [DW-1:0] gpio_hi_out,
  output logic [DW-1:0] gpio_hi_oe,
  output logic [LW-1:0] divisor
);
  localparam logic [DW-1:0] OVR_MASK = DW'(ENG_PINS);

  logic [1:0]    rst_sync;
  logic          rst_ni;
  logic          lo_wr, hi_wr, div_wr;
  logic [DW-1:0] wr_val, wr_oe;
  logic [LW-1:0] div_val, div_q, div_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  sercmd_parser #(.DW(DW), .LW(LW)) u_parser (
    .clk(clk), .rst_ni(rst_ni),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data),
    .eng_busy(eng_busy),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_op(eng_cmd_op), .eng_cmd_len(eng_cmd_len),
    .eng_dat_valid(eng_dat_valid), .eng_dat(eng_dat), .eng_dat_ready(eng_dat_ready),
    .lo_in(gpio_lo_in), .hi_in(gpio_hi_in),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_val(wr_val), .wr_oe(wr_oe),
    .div_wr(div_wr), .div_val(div_val)
  );

  sercmd_gpio_port #(.W(DW)) u_port_lo (
    .clk(clk), .rst_ni(rst_ni), .wr_en(lo_wr), .wr_val(wr_val), .wr_oe(wr_oe),
    .ovr_en(eng_busy), .ovr_mask(OVR_MASK), .ovr_val(eng_pin_val),
    .pin_out(gpio_lo_out), .pin_oe(gpio_lo_oe)
  );

  sercmd_gpio_port #(.W(DW)) u_port_hi (
    .clk(clk), .rst_ni(rst_ni), .wr_en(hi_wr), .wr_val(wr_val), .wr_oe(wr_oe),
    .ovr_en(1'b0), .ovr_mask('0), .ovr_val('0),
    .pin_out(gpio_hi_out), .pin_oe(gpio_hi_oe)
  );

  always_comb begin
    div_d = div_q;
    if (div_wr) div_d = div_val;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end
  assign divisor = div_q;
endmodule

// File: rtl/sercmd_dispatch_chk.sv
module sercmd_dispatch_chk #(
  parameter int DW = 8,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          eng_busy,
  input logic          eng_cmd_valid,
  input logic          eng_cmd_ready,
  input logic [DW-2:0] eng_cmd_op,
  input logic [LW-1:0] eng_cmd_len,
  input logic          eng_dat_valid,
  input logic          lo_wr,
  input logic          hi_wr,
  input logic          div_wr,
  input logic [DW-1:0] gpio_lo_oe,
  input logic [DW-1:0] gpio_hi_oe,
  input logic [LW-1:0] divisor
);
  // R2
  lo_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(gpio_lo_oe) |-> $past(lo_wr));
  // R3
  hi_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(gpio_hi_oe) |-> $past(hi_wr));
  // R5
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(divisor) |-> $past(div_wr));
  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_len)));
  // R7
  cmd_dat_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(eng_cmd_valid && eng_dat_valid));
  // R9
  busy_order_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_busy |-> !(lo_wr || hi_wr || div_wr));
endmodule

bind sercmd_dispatch sercmd_dispatch_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .eng_busy(eng_busy),
  .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
  .eng_cmd_op(eng_cmd_op), .eng_cmd_len(eng_cmd_len),
  .eng_dat_valid(eng_dat_valid), .lo_wr(lo_wr), .hi_wr(hi_wr), .div_wr(div_wr),
  .gpio_lo_oe(gpio_lo_oe), .gpio_hi_oe(gpio_hi_oe), .divisor(divisor)
);

// File: tb/sercmd_dispatch_bench.sv
`timescale 1ns/1ps
module sercmd_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;
  logic        eng_cmd_valid;
  logic        eng_cmd_ready = 1'b1;
  logic [6:0]  eng_cmd_op;
  logic [15:0] eng_cmd_len;
  logic        eng_dat_valid;
  logic [7:0]  eng_dat;
  logic        eng_dat_ready = 1'b1;
  logic        eng_busy = 1'b0;
  logic [7:0]  eng_pin_val = 8'h00;
  logic [7:0]  gpio_lo_in = 8'h00, gpio_hi_in = 8'h00;
  logic [7:0]  gpio_lo_out, gpio_lo_oe, gpio_hi_out, gpio_hi_oe;
  logic [15:0] divisor;

  int checks = 0;
  int fails  = 0;
  int busy_cnt = 0;
  bit done = 1'b0;

  logic [7:0]  exp_out[$];
  logic [22:0] exp_cmd[$];
  logic [7:0]  exp_dat[$];

  always #5 clk = ~clk;

  sercmd_dispatch u_sercmd_dispatch (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // engine model: busy for 40 cycles after each accepted command
  always @(negedge clk) begin
    if (!rst_n) busy_cnt = 0;
    else if (eng_cmd_valid && eng_cmd_ready) busy_cnt = 40;
    else if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    eng_busy = (busy_cnt != 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_out.size() == 0) check(1'b0, "R4/R8 unexpected out", out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_out.pop_front();
          check(out_data == e, "R4/R8 out byte", out_data, e);
        end
      end
      if (eng_cmd_valid && eng_cmd_ready) begin
        if (exp_cmd.size() == 0) check(1'b0, "R6 unexpected cmd", {eng_cmd_op, eng_cmd_len}, 0);
        else begin
          logic [22:0] e;
          e = exp_cmd.pop_front();
          check({eng_cmd_op, eng_cmd_len} == e, "R6 engine cmd", {eng_cmd_op, eng_cmd_len}, e);
        end
      end
      if (eng_dat_valid && eng_dat_ready) begin
        if (exp_dat.size() == 0) check(1'b0, "R7 unexpected data", eng_dat, 0);
        else begin
          logic [7:0] e;
          e = exp_dat.pop_front();
          check(eng_dat == e, "R7 engine data", eng_dat, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(gpio_lo_oe == 0 && gpio_hi_oe == 0, "R1 directions", {gpio_lo_oe, gpio_hi_oe}, 0);
    check(gpio_lo_out == 0 && gpio_hi_out == 0, "R1 levels", {gpio_lo_out, gpio_hi_out}, 0);
    check(divisor == 0 && !out_valid && !eng_cmd_valid, "R1 divisor/valids",
          {divisor, out_valid, eng_cmd_valid}, 0);

    // R2 low port write: level 0x13 then mask 0x1B
    send(8'h80); send(8'h13);
    @(negedge clk);
    check(gpio_lo_out == 0 && gpio_lo_oe == 0, "R2 no change before mask",
          {gpio_lo_out, gpio_lo_oe}, 0);
    send(8'h1B);
    @(negedge clk);
    check(gpio_lo_out == 8'h13 && gpio_lo_oe == 8'h1B, "R2 level+dir together",
          {gpio_lo_out, gpio_lo_oe}, 16'h131B);

    // R3 high port write
    send(8'h82); send(8'hC4); send(8'hF0);
    @(negedge clk);
    check(gpio_hi_out == 8'hC4 && gpio_hi_oe == 8'hF0, "R3 high port",
          {gpio_hi_out, gpio_hi_oe}, 16'hC4F0);
    check(gpio_lo_out == 8'h13 && gpio_lo_oe == 8'h1B, "R3 low port untouched",
          {gpio_lo_out, gpio_lo_oe}, 16'h131B);

    // R4 reads
    gpio_lo_in = 8'hA5; gpio_hi_in = 8'h3C;
    exp_out.push_back(8'hA5); send(8'h81);
    exp_out.push_back(8'h3C); send(8'h83);

    // R5 divisor
    send(8'h86); send(8'h05); send(8'h00);
    @(negedge clk);
    check(divisor == 16'd5, "R5 divisor 5", divisor, 5);
    send(8'h86); send(8'h34);
    @(negedge clk);
    check(divisor == 16'd5, "R5 no half update", divisor, 5);
    send(8'h12);
    @(negedge clk);
    check(divisor == 16'h1234, "R5 divisor 0x1234", divisor, 16'h1234);

    // R8 undecodable command, then a read to show decoding resumes
    exp_out.push_back(8'hFA); exp_out.push_back(8'h8F); send(8'h8F);
    exp_out.push_back(8'hA5); send(8'h81);

    // R6 R7 write transfer: op 0x11, length 1 => two payload bytes
    eng_pin_val = 8'h05;
    exp_cmd.push_back({7'h11, 16'h0001});
    exp_dat.push_back(8'h3F); exp_dat.push_back(8'h06);
    send(8'h11); send(8'h01); send(8'h00); send(8'h3F); send(8'h06);
    repeat (2) @(negedge clk);
    // R9 command held off while busy
    check(eng_busy && !in_ready, "R9 stall while busy", {eng_busy, in_ready}, 2'b10);
    // R10 owned pins follow engine: (0x13 & ~0x07) | 0x05 = 0x15
    check(gpio_lo_out == 8'h15, "R10 override while busy", gpio_lo_out, 8'h15);
    check(gpio_hi_out == 8'hC4, "R10 high port not overridden", gpio_hi_out, 8'hC4);
    send(8'h80); send(8'h08); send(8'h0F);
    @(negedge clk);
    check(!eng_busy && gpio_lo_out == 8'h08 && gpio_lo_oe == 8'h0F,
          "R9 write after transfer / R10 released", {eng_busy, gpio_lo_out, gpio_lo_oe}, 16'h080F);

    // R7 read-only transfer (bit 4 clear): next byte is a command
    while (eng_busy) @(negedge clk);
    exp_cmd.push_back({7'h20, 16'h0003});
    send(8'h20); send(8'h03); send(8'h00);
    exp_out.push_back(8'h3C); send(8'h83);

    repeat (60) @(negedge clk);
    check(exp_out.size() == 0 && exp_cmd.size() == 0 && exp_dat.size() == 0,
          "R4/R6/R7 scoreboard drained", exp_out.size() + exp_cmd.size() + exp_dat.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule